// File: doc/BRIEF.md
# YUV 4:2:2 Pixel Bus Receiver

This block takes in a 4:2:2 luma/chroma pixel stream and turns it into one assembled pixel per output beat. Each beat carries one luma sample, the chroma sample that goes with it, and a tag that says whether the chroma is Cb or Cr. Everything runs on the double-rate pixel clock `clk`. Two bus formats are supported, chosen by a configuration input.

In narrow mode a single byte lane carries chroma and luma, time-multiplexed at one byte per clock. In wide mode luma and chroma travel on separate lanes. Wide-mode samples are qualified by a half-rate enable line that toggles every clock, and a polarity setting picks the level at which samples are taken. An optional pixel-valid qualifier can stall the stream for any number of cycles. A line-start pulse realigns the chroma phase. The bus carries no embedded timing codes.

The heart of the block is a four-state phase machine:

- States: `PH_CB` (expect Cb), `PH_Y0` (expect the luma paired with Cb), `PH_CR` (expect Cr), `PH_Y1` (expect the luma paired with Cr).
- Narrow-mode transitions: on each qualified cycle the machine steps PH_CB→PH_Y0→PH_CR→PH_Y1→PH_CB.
- Wide-mode transitions: on each qualified cycle the machine alternates PH_CB↔PH_CR.
- Line-start transition: `line_start` forces any state to PH_CB.

Top module: `yuv422_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0.
- R2: In narrow mode (`cfg_wide`=0), after a line start the qualified bytes on `bus_lo` are taken in the order Cb, Y, Cr, Y. The first luma byte produces a beat with Y=that byte, C=the preceding Cb and `out_is_cr`=0. The second luma byte produces a beat with C=the preceding Cr and `out_is_cr`=1. Each beat appears one clock after its qualified luma byte.
- R3: In narrow mode `out_valid` is never high on two consecutive clocks.
- R4: In wide mode (`cfg_wide`=1) a cycle is qualified only when `half_en` equals `cfg_en_pol` (0 means sample while low). A qualified cycle gives a beat one clock later with Y=`bus_lo` and C=`bus_hi`.
- R5: In wide mode `out_is_cr` is 0 on the first beat after a line start and then alternates 1, 0, 1, … on successive beats.
- R6: When `cfg_pv_en`=1 and `pix_valid`=0, nothing is captured and the phase does not advance. The next beat continues the sequence exactly where it stopped.
- R7: When `cfg_pv_en`=0, `pix_valid` has no effect on the output stream.
- R8: `cfg_wide`, `cfg_en_pol` and `cfg_pv_en` are sampled only on clock edges while `rst_n` is low. Changing them after reset does not change the behaviour.
- R9: A cycle with `line_start`=1 captures nothing, produces no beat on the next clock, and returns the phase to Cb in both modes.
- R10: In narrow mode `half_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate pixel clock |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| cfg_wide | input | 1 | 0: multiplexed single lane, 1: split luma/chroma lanes |
| cfg_en_pol | input | 1 | Wide mode: level of `half_en` at which samples are taken |
| cfg_pv_en | input | 1 | 1: honour `pix_valid`, 0: ignore it |
| line_start | input | 1 | Line-start event; realigns the chroma phase |
| half_en | input | 1 | Half-rate enable, toggles every clock |
| pix_valid | input | 1 | Pixel-valid qualifier |
| bus_lo | input | DW | Narrow: multiplexed bytes; wide: luma |
| bus_hi | input | DW | Wide: chroma; unused in narrow mode |
| out_valid | output | 1 | One pulse per assembled pixel |
| out_y | output | DW | Luma of the beat |
| out_c | output | DW | Chroma of the beat |
| out_is_cr | output | 1 | 1: `out_c` is Cr, 0: Cb |

## Verification
The bench builds the block with the default lane width DW=8. It runs four reset sessions, each with a different configuration:

- narrow mode with pixel-valid honoured;
- narrow mode with pixel-valid ignored;
- wide mode with low-level sampling;
- wide mode with high-level sampling.

Within these sessions it inserts stalls of different lengths, line starts in the middle of a group, and configuration changes after reset. Together these reach every state and every transition of the phase machine, and both enable polarities. A byte width of 8 keeps the data counters short, so wrap-around of the byte values is also exercised.

// File: rtl/yuv422_rx_pkg.sv
package yuv422_rx_pkg;
    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } phase_t;

    typedef struct packed {
        logic wide;
        logic en_pol;
        logic pv_en;
    } rx_cfg_t;
endpackage

// File: rtl/yuv422_rx_cfg.sv
module yuv422_rx_cfg
    import yuv422_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rx_cfg_t cfg_in,
    output rx_cfg_t cfg_q
);
    // Capture configuration only while the block is held in reset
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_in;
    end

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q))
        else $error("R8 configuration changed outside reset");
endmodule

// File: rtl/yuv422_rx_qual.sv
module yuv422_rx_qual
    import yuv422_rx_pkg::*;
(
    input  rx_cfg_t cfg,
    input  logic    half_en,
    input  logic    pix_valid,
    output logic    qual
);
    logic pv_ok;
    logic phase_ok;

    always_comb begin
        pv_ok    = !cfg.pv_en || pix_valid;
        phase_ok = cfg.wide ? (half_en == cfg.en_pol) : 1'b1;
        qual     = pv_ok && phase_ok;
    end
endmodule

// File: rtl/yuv422_rx_fsm.sv
module yuv422_rx_fsm
    import yuv422_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          qual,
    input  logic          line_start,
    input  logic [DW-1:0] bus_lo,
    input  logic [DW-1:0] bus_hi,
    output logic          out_valid,
    output logic [DW-1:0] out_y,
    output logic [DW-1:0] out_c,
    output logic          out_is_cr
);
    phase_t        ph_q;
    phase_t        ph_n;
    logic [DW-1:0] c_hold;
    logic          step;

    assign step = qual && !line_start;

    // Next phase
    always_comb begin
        ph_n = ph_q;
        if (line_start) begin
            ph_n = PH_CB;
        end else if (qual) begin
            if (wide) begin
                ph_n = (ph_q == PH_CB) ? PH_CR : PH_CB;
            end else begin
                unique case (ph_q)
                    PH_CB: ph_n = PH_Y0;
                    PH_Y0: ph_n = PH_CR;
                    PH_CR: ph_n = PH_Y1;
                    PH_Y1: ph_n = PH_CB;
                endcase
            end
        end
    end

    // Phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_CB;
        else        ph_q <= ph_n;
    end

    // Registered outputs and chroma hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_y     <= '0;
            out_c     <= '0;
            out_is_cr <= 1'b0;
            c_hold    <= '0;
        end else begin
            out_valid <= 1'b0;
            if (step) begin
                if (wide) begin
                    out_valid <= 1'b1;
                    out_y     <= bus_lo;
                    out_c     <= bus_hi;
                    out_is_cr <= (ph_q == PH_CR);
                end else begin
                    unique case (ph_q)
                        PH_CB, PH_CR: c_hold <= bus_lo;
                        PH_Y0: begin
                            out_valid <= 1'b1;
                            out_y     <= bus_lo;
                            out_c     <= c_hold;
                            out_is_cr <= 1'b0;
                        end
                        PH_Y1: begin
                            out_valid <= 1'b1;
                            out_y     <= bus_lo;
                            out_c     <= c_hold;
                            out_is_cr <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    a_r6_stall_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> !out_valid)
        else $error("R6 beat without qualified cycle");

    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && out_valid) |=> !out_valid)
        else $error("R3 consecutive beats in narrow mode");

    a_r9_line_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !out_valid)
        else $error("R9 beat after line start");

    a_r5_wide_first_cb: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && $past(line_start) && qual && !line_start) |=> (out_valid && !out_is_cr))
        else $error("R5 first wide beat after line start not Cb");
endmodule

// File: rtl/yuv422_rx.sv
module yuv422_rx
    import yuv422_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wide,
    input  logic          cfg_en_pol,
    input  logic          cfg_pv_en,
    input  logic          line_start,
    input  logic          half_en,
    input  logic          pix_valid,
    input  logic [DW-1:0] bus_lo,
    input  logic [DW-1:0] bus_hi,
    output logic          out_valid,
    output logic [DW-1:0] out_y,
    output logic [DW-1:0] out_c,
    output logic          out_is_cr
);
    rx_cfg_t cfg_in;
    rx_cfg_t cfg_q;
    logic    qual;

    assign cfg_in = '{wide: cfg_wide, en_pol: cfg_en_pol, pv_en: cfg_pv_en};

    yuv422_rx_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    yuv422_rx_qual u_qual (
        .cfg       (cfg_q),
        .half_en   (half_en),
        .pix_valid (pix_valid),
        .qual      (qual)
    );

    yuv422_rx_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide       (cfg_q.wide),
        .qual       (qual),
        .line_start (line_start),
        .bus_lo     (bus_lo),
        .bus_hi     (bus_hi),
        .out_valid  (out_valid),
        .out_y      (out_y),
        .out_c      (out_c),
        .out_is_cr  (out_is_cr)
    );
endmodule

// File: tb/test_yuv422_rx.sv
`timescale 1ns/1ps
module test_yuv422_rx;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wide = 1'b0, cfg_en_pol = 1'b0, cfg_pv_en = 1'b1;
    logic          line_start = 1'b0, half_en = 1'b0, pix_valid = 1'b0;
    logic [DW-1:0] bus_lo = '0, bus_hi = '0;
    logic          out_valid, out_is_cr;
    logic [DW-1:0] out_y, out_c;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    yuv422_rx #(.DW(DW)) i_yuv422_rx (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_en_pol(cfg_en_pol),
        .cfg_pv_en(cfg_pv_en), .line_start(line_start), .half_en(half_en),
        .pix_valid(pix_valid), .bus_lo(bus_lo), .bus_hi(bus_hi),
        .out_valid(out_valid), .out_y(out_y), .out_c(out_c), .out_is_cr(out_is_cr)
    );

    // Behavioural reference model
    bit m_wide, m_pol, m_pven;
    int m_ph = 0;
    int m_hold = 0;
    bit e_valid = 0, e_cr = 0;
    int e_y = 0, e_c = 0;
    bit prev_valid = 0;
    bit after_reset = 0;

    always @(posedge clk) begin
        bit q;
        if (!rst_n) begin
            m_wide = cfg_wide; m_pol = cfg_en_pol; m_pven = cfg_pv_en;
            m_ph = 0; e_valid = 0; after_reset = 1;
        end else begin
            e_valid = 0;
            q = (!m_pven || pix_valid) && (m_wide ? (half_en == m_pol) : 1'b1);
            if (line_start) m_ph = 0;
            else if (q) begin
                if (m_wide) begin
                    e_valid = 1; e_y = bus_lo; e_c = bus_hi; e_cr = (m_ph == 1);
                    m_ph = 1 - m_ph;
                end else begin
                    if (m_ph == 0 || m_ph == 2) m_hold = bus_lo;
                    else begin
                        e_valid = 1; e_y = bus_lo; e_c = m_hold; e_cr = (m_ph == 3);
                    end
                    m_ph = (m_ph + 1) % 4;
                end
            end
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        checks++;
        if (out_valid !== e_valid) begin
            failures++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, e_valid);
        end else if (e_valid && (out_y !== DW'(e_y) || out_c !== DW'(e_c) || out_is_cr !== e_cr)) begin
            failures++;
            $display("FAIL %s beat actual y=%0h c=%0h cr=%0b expected y=%0h c=%0h cr=%0b",
                     tag, out_y, out_c, out_is_cr, e_y[DW-1:0], e_c[DW-1:0], e_cr);
        end
        if (rst_n && !m_wide) begin
            checks++; // R3 no back-to-back beats in narrow mode
            if (out_valid && prev_valid) begin
                failures++;
                $display("FAIL R3 consecutive beats actual=1 expected=0");
            end
        end
        prev_valid = out_valid;
    end

    logic [DW-1:0] cnt = '0;

    task automatic step(input bit ls, input bit pv);
        @(negedge clk);
        #0.5;
        line_start = ls;
        pix_valid  = pv;
        half_en    = ~half_en;
        bus_lo     = cnt;
        bus_hi     = cnt ^ 8'hA5;
        cnt        = cnt + 8'd7;
    endtask

    task automatic do_reset(input bit w, input bit pol, input bit pv);
        @(negedge clk);
        #0.5;
        rst_n = 1'b0; cfg_wide = w; cfg_en_pol = pol; cfg_pv_en = pv;
        line_start = 0; pix_valid = 0;
        repeat (3) @(negedge clk);
        checks++; // R1 reset state
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 out_valid in reset actual=%0b expected=0", out_valid);
        end
        #0.5;
        rst_n = 1'b1;
    endtask

    initial begin
        #(4.0 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Session 1: narrow mode, pixel-valid honoured
        tag = "R1";
        do_reset(1'b0, 1'b0, 1'b1);
        step(1, 1);
        tag = "R2";
        for (int i = 0; i < 16; i++) step(0, 1);
        tag = "R6";
        for (int i = 0; i < 24; i++) step(0, (i % 3) != 1);
        for (int i = 0; i < 5; i++) step(0, 0);
        tag = "R10";
        for (int i = 0; i < 12; i++) step(0, 1);
        tag = "R9";
        step(0, 1);
        step(1, 1);
        for (int i = 0; i < 10; i++) step(0, 1);
        step(0, 1); step(0, 1); step(0, 1);
        step(1, 1);
        for (int i = 0; i < 8; i++) step(0, 1);

        // Session 2: narrow mode, pixel-valid ignored
        tag = "R1";
        do_reset(1'b0, 1'b0, 1'b0);
        tag = "R7";
        step(1, 0);
        for (int i = 0; i < 20; i++) step(0, 0);
        for (int i = 0; i < 8; i++) step(0, i[0]);

        // Session 3: wide mode, sample while enable low
        tag = "R1";
        do_reset(1'b1, 1'b0, 1'b1);
        tag = "R4";
        step(1, 1);
        for (int i = 0; i < 16; i++) step(0, 1);
        tag = "R5";
        for (int i = 0; i < 20; i++) step(0, (i % 5) != 2);
        tag = "R9";
        step(1, 1);
        for (int i = 0; i < 9; i++) step(0, 1);

        // Session 4: wide mode, sample while enable high; config changes later
        tag = "R1";
        do_reset(1'b1, 1'b1, 1'b1);
        tag = "R4";
        step(1, 1);
        for (int i = 0; i < 12; i++) step(0, 1);
        tag = "R8";
        @(negedge clk);
        #0.5;
        cfg_wide = 1'b0; cfg_en_pol = 1'b0; cfg_pv_en = 1'b0;
        for (int i = 0; i < 16; i++) step(0, i % 4 != 0);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule